// File: doc/BRIEF.md
# Debug memory-port address and packing engine

This block sits between a 32-bit debug register port and a simple request/acknowledge memory master. It keeps a control word and a transfer address register. An access to the data register, or to one of four banked data slots, becomes one or more bus beats. The block drives the address, the size and the byte enables of each beat. When a beat finishes without error, the block steps the transfer address by the access size. It only steps when the control word selects a stepping mode, and the step wraps inside a 1 KB window.

In packed mode, one 32-bit register access becomes four byte beats or two halfword beats. The write word is split into these beats, and the beats of a read are gathered back into one word. The banked slots reach the aligned four-word window around the transfer address, with no stepping. A debug-enable input gates every beat. The register port stalls until the last beat of an access completes.

Register map, by word index (byte offset / 4): 0 control, 1 transfer address, 3 data, 4 to 7 banked slots (byte offsets 0x10 to 0x1C).

Top module: `dmp_engine`

## Requirements
- R1: After reset, the control word reads 0x00000042 when debug-enable is high. Size [2:0] is 010, step mode [5:4] is 00, the debug-enable status is in [6], busy is in [7] and the sticky error is in [9]. The transfer address reads 0 and no bus request is raised.
- R2: Writes to word 0 set size and step mode, and writes to word 1 set the transfer address. Both read back as written.
- R3: In step mode 01, each beat that completes OK adds 1, 2 or 4 to the transfer address, for size 000, 001 or 010. In step mode 00, the address does not change.
- R4: A step changes only address bits [9:0], which wrap modulo 1024. Bits [31:10] are held.
- R5: A beat that ends with an error response leaves the address unchanged, ends the access and sets bit 9 of the control word. A control write with bit 9 set clears bit 9.
- R6: In step mode 10 with size 000, one data access issues four byte beats. Beat k carries byte k of the register word, on the lane given by address bits [1:0]. A read gathers the four beats into one word.
- R7: In step mode 10 with size 001, one access issues two halfword beats (enables 0011 or 1100, by address bit 1). With size 010, mode 10 acts like mode 01.
- R8: A banked slot n (word 4+n) issues one word beat to {address[31:4], n[1:0], 00} with bus size 2 and enables 1111. The size field is ignored, and the transfer address never steps.
- R9: While debug-enable is low, a data access issues no beat. It completes at once, and a read returns 0. If debug-enable is low when a packed beat completes, the remaining beats are dropped.
- R10: Step mode 11, or a size of 011 or above, makes a data access complete with no beat.
- R11: A request keeps its address and enables stable until it is acknowledged. The register port does not complete a data access while a beat is outstanding.
- R12: Bus size is encoded 0 byte, 1 halfword, 2 word. In single mode, the byte enables follow address bits [1:0], and read data outside the enabled lanes is returned as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dbg_en | input | 1 | Debug enable; low blocks bus beats |
| reg_valid | input | 1 | Register access request, held until ready |
| reg_write | input | 1 | 1 = register write |
| reg_waddr | input | 6 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_ready | output | 1 | Register access completes this cycle |
| reg_rdata | output | 32 | Register read data, valid with ready |
| mem_req | output | 1 | Bus beat request |
| mem_write | output | 1 | Bus beat is a write |
| mem_addr | output | 32 | Bus byte address |
| mem_size | output | 2 | Bus beat size |
| mem_be | output | 4 | Byte lane enables |
| mem_wdata | output | 32 | Bus write data |
| mem_ack | input | 1 | Beat complete |
| mem_err | input | 1 | Error response with ack |
| mem_rdata | input | 32 | Bus read data, valid with ack |

## Verification
Two events can land on the same acknowledge edge. One is a completed beat that would step the address and launch the next packed beat. The other is either an error response that must suppress both, or a fall of debug-enable that must cancel the rest of the sequence while keeping the step already earned. The responder injects an error on a chosen beat index, or drops debug-enable on the same falling edge where it raises acknowledge. The bench then judges the outcome from the number of logged beats and the transfer address read back.

// File: rtl/dmp_pkg.sv
`timescale 1ns/1ps
package dmp_pkg;
    localparam int ADDR_W  = 32;
    localparam int DATA_W  = 32;
    localparam int WRAP_W  = 10;
    localparam int WIDX_W  = 6;

    localparam logic [WIDX_W-1:0] WI_CTRL = 6'd0;
    localparam logic [WIDX_W-1:0] WI_ADDR = 6'd1;
    localparam logic [WIDX_W-1:0] WI_DATA = 6'd3;
    localparam logic [3:0]        WI_BANK_HI = 4'd1;

    typedef enum logic [1:0] {
        INC_NONE = 2'b00,
        INC_ONE  = 2'b01,
        INC_PACK = 2'b10,
        INC_RSVD = 2'b11
    } inc_e;

    typedef struct packed {
        logic       err;
        inc_e       inc;
        logic [2:0] size;
    } ctrl_t;

    typedef struct packed {
        logic       write;
        logic       banked;
        logic [1:0] slot;
        logic       pk;
        logic [1:0] esize;
        logic [2:0] beats;
    } ctx_t;

    function automatic logic [2:0] beats_for(inc_e inc, logic [1:0] sz);
        if (inc == INC_PACK && sz == 2'd0)      return 3'd4;
        else if (inc == INC_PACK && sz == 2'd1) return 3'd2;
        else                                    return 3'd1;
    endfunction

    function automatic logic [3:0] lanes_for(logic [1:0] sz, logic [1:0] a);
        case (sz)
            2'd0:    return 4'b0001 << a;
            2'd1:    return a[1] ? 4'b1100 : 4'b0011;
            default: return 4'b1111;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] lane_mask(logic [3:0] be);
        logic [DATA_W-1:0] m;
        for (int i = 0; i < 4; i++) m[8*i +: 8] = {8{be[i]}};
        return m;
    endfunction
endpackage

// File: rtl/dmp_regs.sv
`timescale 1ns/1ps
module dmp_regs
    import dmp_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int WW = WRAP_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_ctrl,
    input  logic          wr_addr,
    input  logic [31:0]   wdata,
    input  logic          adv,
    input  logic [3:0]    step,
    input  logic          set_err,
    output ctrl_t         ctrl,
    output logic [AW-1:0] tar
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '{err: 1'b0, inc: INC_NONE, size: 3'b010};
            tar  <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl.size <= wdata[2:0];
                ctrl.inc  <= inc_e'(wdata[5:4]);
            end
            if (set_err)                 ctrl.err <= 1'b1;
            else if (wr_ctrl && wdata[9]) ctrl.err <= 1'b0;
            if (wr_addr)  tar <= AW'(wdata);
            else if (adv) tar[WW-1:0] <= tar[WW-1:0] + WW'(step);
        end
    end
endmodule

// File: rtl/dmp_lanes.sv
`timescale 1ns/1ps
module dmp_lanes
    import dmp_pkg::*;
(
    input  ctx_t              ctx,
    input  logic [1:0]        beat,
    input  logic [1:0]        addr_lo,
    input  logic [DATA_W-1:0] wbuf,
    input  logic [DATA_W-1:0] rdata,
    output logic [3:0]        be,
    output logic [DATA_W-1:0] wdata_o,
    output logic [DATA_W-1:0] mrg,
    output logic [DATA_W-1:0] msk
);
    always_comb begin
        be = lanes_for(ctx.esize, addr_lo);
        if (ctx.pk && ctx.esize == 2'd0) begin
            wdata_o = {4{wbuf[{beat, 3'b000} +: 8]}};
            mrg     = {4{rdata[{addr_lo, 3'b000} +: 8]}};
            msk     = 32'h0000_00FF << {beat, 3'b000};
        end else if (ctx.pk && ctx.esize == 2'd1) begin
            wdata_o = {2{wbuf[{beat[0], 4'b0000} +: 16]}};
            mrg     = {2{rdata[{addr_lo[1], 4'b0000} +: 16]}};
            msk     = 32'h0000_FFFF << {beat[0], 4'b0000};
        end else begin
            wdata_o = wbuf;
            mrg     = rdata;
            msk     = lane_mask(be);
        end
    end
endmodule

// File: rtl/dmp_seq.sv
`timescale 1ns/1ps
module dmp_seq
    import dmp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  ctx_t              ctx_in,
    input  logic [DATA_W-1:0] wdata_in,
    input  logic              dbg_en,
    input  logic              mem_ack,
    input  logic              mem_err,
    input  logic [DATA_W-1:0] mrg,
    input  logic [DATA_W-1:0] msk,
    output logic              busy,
    output logic              done,
    output ctx_t              ctx,
    output logic [DATA_W-1:0] wbuf,
    output logic [1:0]        beat,
    output logic [DATA_W-1:0] acc,
    output logic              beat_ok,
    output logic              err_evt
);
    typedef enum logic [1:0] {S_IDLE, S_BUS, S_DONE} st_e;
    st_e  st;
    logic last;

    assign busy    = (st == S_BUS);
    assign done    = (st == S_DONE);
    assign beat_ok = busy && mem_ack && !mem_err;
    assign err_evt = busy && mem_ack && mem_err;
    assign last    = ({1'b0, beat} + 3'd1) == ctx.beats;

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= S_IDLE;
            ctx  <= '0;
            wbuf <= '0;
            beat <= '0;
            acc  <= '0;
        end else begin
            case (st)
                S_IDLE: if (start) begin
                    ctx  <= ctx_in;
                    wbuf <= wdata_in;
                    beat <= '0;
                    acc  <= '0;
                    st   <= S_BUS;
                end
                S_BUS: if (mem_ack) begin
                    if (!mem_err && !ctx.write) acc <= (acc & ~msk) | (mrg & msk);
                    if (mem_err || last || !dbg_en) st <= S_DONE;
                    else                            beat <= beat + 2'd1;
                end
                default: st <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dmp_engine.sv
`timescale 1ns/1ps
module dmp_engine
    import dmp_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        dbg_en,
    input  logic        reg_valid,
    input  logic        reg_write,
    input  logic [5:0]  reg_waddr,
    input  logic [31:0] reg_wdata,
    output logic        reg_ready,
    output logic [31:0] reg_rdata,
    output logic        mem_req,
    output logic        mem_write,
    output logic [31:0] mem_addr,
    output logic [1:0]  mem_size,
    output logic [3:0]  mem_be,
    output logic [31:0] mem_wdata,
    input  logic        mem_ack,
    input  logic        mem_err,
    input  logic [31:0] mem_rdata
);
    ctrl_t              ctrl;
    logic [ADDR_W-1:0]  tar;
    ctx_t               ctx, ctx_in;
    logic [DATA_W-1:0]  wbuf, acc, mrg, msk;
    logic [1:0]         beat;
    logic               busy, done, idle, beat_ok, err_evt;
    logic               is_ctrl, is_addr, is_data, is_bank, launch_ok, start;
    logic               wr_ctrl, wr_addr, adv;

    assign is_ctrl   = reg_waddr == WI_CTRL;
    assign is_addr   = reg_waddr == WI_ADDR;
    assign is_data   = reg_waddr == WI_DATA;
    assign is_bank   = reg_waddr[5:2] == WI_BANK_HI;
    assign idle      = !busy && !done;
    assign launch_ok = dbg_en && (is_bank ||
                       (is_data && ctrl.size <= 3'd2 && ctrl.inc != INC_RSVD));
    assign start     = idle && reg_valid && launch_ok;
    assign wr_ctrl   = idle && reg_valid && reg_write && is_ctrl;
    assign wr_addr   = idle && reg_valid && reg_write && is_addr;
    assign adv       = beat_ok && !ctx.banked &&
                       (ctrl.inc == INC_ONE || ctrl.inc == INC_PACK);

    always_comb begin
        ctx_in.write  = reg_write;
        ctx_in.banked = is_bank;
        ctx_in.slot   = reg_waddr[1:0];
        ctx_in.pk     = (ctrl.inc == INC_PACK) && !is_bank;
        ctx_in.esize  = is_bank ? 2'd2 : ctrl.size[1:0];
        ctx_in.beats  = is_bank ? 3'd1 : beats_for(ctrl.inc, ctrl.size[1:0]);
    end

    dmp_regs #(.AW(ADDR_W), .WW(WRAP_W)) i_regs (
        .clk(clk), .rst(rst), .wr_ctrl(wr_ctrl), .wr_addr(wr_addr),
        .wdata(reg_wdata), .adv(adv), .step(4'd1 << ctx.esize),
        .set_err(err_evt), .ctrl(ctrl), .tar(tar)
    );

    dmp_seq i_seq (
        .clk(clk), .rst(rst), .start(start), .ctx_in(ctx_in),
        .wdata_in(reg_wdata), .dbg_en(dbg_en), .mem_ack(mem_ack),
        .mem_err(mem_err), .mrg(mrg), .msk(msk), .busy(busy), .done(done),
        .ctx(ctx), .wbuf(wbuf), .beat(beat), .acc(acc),
        .beat_ok(beat_ok), .err_evt(err_evt)
    );

    assign mem_addr = ctx.banked ? {tar[31:4], ctx.slot, 2'b00} : tar;

    dmp_lanes i_lanes (
        .ctx(ctx), .beat(beat), .addr_lo(mem_addr[1:0]), .wbuf(wbuf),
        .rdata(mem_rdata), .be(mem_be), .wdata_o(mem_wdata),
        .mrg(mrg), .msk(msk)
    );

    assign mem_req   = busy;
    assign mem_write = ctx.write;
    assign mem_size  = ctx.esize;
    assign reg_ready = done || (idle && reg_valid && !launch_ok);

    always_comb begin
        if (done)         reg_rdata = ctx.write ? '0 : acc;
        else if (is_ctrl) reg_rdata = {22'b0, ctrl.err, 1'b0, busy, dbg_en,
                                       ctrl.inc, 1'b0, ctrl.size};
        else if (is_addr) reg_rdata = tar;
        else              reg_rdata = '0;
    end
endmodule

// File: rtl/dmp_engine_chk.sv
`timescale 1ns/1ps
module dmp_engine_chk (
    input logic        clk,
    input logic        rst,
    input logic        dbg_en,
    input logic        reg_ready,
    input logic [5:0]  reg_waddr,
    input logic        mem_req,
    input logic        mem_ack,
    input logic        mem_err,
    input logic [31:0] mem_addr,
    input logic [1:0]  mem_size,
    input logic [3:0]  mem_be,
    input logic [31:0] tar
);
    p_hold_r11: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_be));

    p_stall_r11: assert property (@(posedge clk) disable iff (rst)
        reg_ready |-> !mem_req);

    p_gate_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_req) |-> $past(dbg_en));

    p_bank_word_r8: assert property (@(posedge clk) disable iff (rst)
        mem_req && reg_waddr[5:2] == 4'd1 |-> mem_size == 2'd2 && mem_be == 4'hF);

    p_wrap_r4: assert property (@(posedge clk) disable iff (rst)
        mem_req && $past(mem_req && mem_ack) |-> mem_addr[31:10] == $past(mem_addr[31:10]));

    p_err_hold_r5: assert property (@(posedge clk) disable iff (rst)
        mem_ack && mem_err |=> $stable(tar));
endmodule

bind dmp_engine dmp_engine_chk i_chk (.*);

// File: tb/test_dmp_engine.sv
`timescale 1ns/1ps
module test_dmp_engine;
    logic        clk = 0, rst = 1, dbg_en = 1;
    logic        reg_valid = 0, reg_write = 0;
    logic [5:0]  reg_waddr = 0;
    logic [31:0] reg_wdata = 0;
    logic        reg_ready;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_write;
    logic [31:0] mem_addr, mem_wdata;
    logic [1:0]  mem_size;
    logic [3:0]  mem_be;
    logic        mem_ack = 0, mem_err = 0;
    logic [31:0] mem_rdata = 0;

    dmp_engine i_dmp_engine (.*);

    always #5 clk = ~clk;

    int checks = 0, fails = 0;
    int lat = 0, err_at = -1, drop_at = -1, nb = 0, cyc = 0;
    logic [31:0] mem [0:255];
    logic [31:0] la  [0:7];
    logic [3:0]  lbe [0:7];
    logic [1:0]  lsz [0:7];

    localparam logic [5:0] W_CTRL = 6'd0, W_ADDR = 6'd1, W_DATA = 6'd3;

    initial forever begin @(posedge clk); cyc++; end

    // memory responder: acks at a falling edge, consumed at the next rising edge
    initial begin
        int w;
        w = 0;
        forever begin
            @(negedge clk);
            mem_ack = 0;
            mem_err = 0;
            if (mem_req) begin
                if (w >= lat) begin
                    w = 0;
                    mem_ack = 1;
                    if (nb < 8) begin
                        la[nb] = mem_addr; lbe[nb] = mem_be; lsz[nb] = mem_size;
                    end
                    if (err_at == nb) mem_err = 1;
                    else if (mem_write)
                        for (int b = 0; b < 4; b++)
                            if (mem_be[b]) mem[mem_addr[9:2]][8*b +: 8] = mem_wdata[8*b +: 8];
                    mem_rdata = mem[mem_addr[9:2]];
                    if (drop_at == nb) dbg_en = 0;
                    nb++;
                end else w++;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rw(input logic wr, input logic [5:0] wa, input logic [31:0] wd,
                      output logic [31:0] rd);
        @(negedge clk);
        reg_valid = 1; reg_write = wr; reg_waddr = wa; reg_wdata = wd;
        #1;
        while (!reg_ready) begin @(negedge clk); #1; end
        rd = reg_rdata;
        @(posedge clk); #1;
        reg_valid = 0;
    endtask

    task automatic wreg(input logic [5:0] wa, input logic [31:0] wd);
        logic [31:0] d;
        rw(1'b1, wa, wd, d);
    endtask

    task automatic rreg(input logic [5:0] wa, output logic [31:0] d);
        rw(1'b0, wa, 32'h0, d);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        chk("R1 no request after reset", {31'b0, mem_req}, 32'h0);
        rreg(W_CTRL, d); chk("R1 control reset", d, 32'h42);
        rreg(W_ADDR, d); chk("R1 address reset", d, 32'h0);
    endtask

    task automatic t_regs;
        logic [31:0] d;
        wreg(W_ADDR, 32'h1234_5678); rreg(W_ADDR, d); chk("R2 address readback", d, 32'h1234_5678);
        wreg(W_CTRL, 32'h11);        rreg(W_CTRL, d); chk("R2 control readback", d, 32'h51);
    endtask

    task automatic t_single;
        logic [31:0] d;
        wreg(W_CTRL, 32'h12); wreg(W_ADDR, 32'h100); nb = 0;
        wreg(W_DATA, 32'hCAFE_F00D);
        chk("R3 one beat", nb, 1); chk("R12 word lanes", {28'b0, lbe[0]}, 32'hF);
        chk("R12 word size", {30'b0, lsz[0]}, 32'h2);
        rreg(W_ADDR, d); chk("R3 step 4", d, 32'h104);
        wreg(W_CTRL, 32'h10); wreg(W_ADDR, 32'h101); nb = 0;
        wreg(W_DATA, 32'h0000_AB00);
        chk("R12 byte lane 1", {28'b0, lbe[0]}, 32'h2);
        rreg(W_ADDR, d); chk("R3 step 1", d, 32'h102);
        chk("R12 byte written", mem[8'h40], 32'hCAFE_AB0D);
        rreg(W_DATA, d); chk("R12 read lane masked", d, 32'h00FE_0000);
        wreg(W_CTRL, 32'h02); wreg(W_ADDR, 32'h100);
        rreg(W_DATA, d); chk("R3 read no step", d, 32'hCAFE_AB0D);
        rreg(W_ADDR, d); chk("R3 mode 00 holds address", d, 32'h100);
    endtask

    task automatic t_wrap;
        logic [31:0] d;
        wreg(W_CTRL, 32'h12); wreg(W_ADDR, 32'h0000_43FC);
        wreg(W_DATA, 32'h1);
        rreg(W_ADDR, d); chk("R4 word wrap", d, 32'h0000_4000);
        wreg(W_CTRL, 32'h11); wreg(W_ADDR, 32'h0000_87FE);
        wreg(W_DATA, 32'h2);
        rreg(W_ADDR, d); chk("R4 halfword wrap", d, 32'h0000_8400);
    endtask

    task automatic t_err;
        logic [31:0] d;
        wreg(W_CTRL, 32'h12); wreg(W_ADDR, 32'h200); nb = 0; err_at = 0;
        wreg(W_DATA, 32'h5555_AAAA);
        err_at = -1;
        rreg(W_ADDR, d); chk("R5 no step on error", d, 32'h200);
        rreg(W_CTRL, d); chk("R5 sticky error set", d, 32'h252);
        wreg(W_CTRL, 32'h212);
        rreg(W_CTRL, d); chk("R5 error cleared", d, 32'h52);
        wreg(W_CTRL, 32'h20); wreg(W_ADDR, 32'h240); nb = 0; err_at = 1;
        wreg(W_DATA, 32'h1);
        err_at = -1;
        chk("R5 packed stops at error", nb, 2);
        rreg(W_ADDR, d); chk("R5 only ok beat stepped", d, 32'h241);
        wreg(W_CTRL, 32'h212);
    endtask

    task automatic t_pack_byte;
        logic [31:0] d;
        wreg(W_CTRL, 32'h20); wreg(W_ADDR, 32'h300); nb = 0;
        wreg(W_DATA, 32'h4433_2211);
        chk("R6 four beats", nb, 4);
        for (int k = 0; k < 4; k++) begin
            chk("R6 beat address", la[k], 32'h300 + k);
            chk("R6 beat lane", {28'b0, lbe[k]}, 32'h1 << k);
        end
        chk("R6 packed bytes stored", mem[8'hC0], 32'h4433_2211);
        rreg(W_ADDR, d); chk("R6 address after pack", d, 32'h304);
        wreg(W_ADDR, 32'h300);
        rreg(W_DATA, d); chk("R6 packed read", d, 32'h4433_2211);
    endtask

    task automatic t_pack_half;
        logic [31:0] d;
        wreg(W_CTRL, 32'h21); wreg(W_ADDR, 32'h400); nb = 0;
        wreg(W_DATA, 32'hBBBB_AAAA);
        chk("R7 two beats", nb, 2);
        chk("R7 low half lanes", {28'b0, lbe[0]}, 32'h3);
        chk("R7 high half lanes", {28'b0, lbe[1]}, 32'hC);
        chk("R7 halves stored", mem[8'h00], 32'hBBBB_AAAA);
        wreg(W_ADDR, 32'h400);
        rreg(W_DATA, d); chk("R7 packed half read", d, 32'hBBBB_AAAA);
        wreg(W_CTRL, 32'h22); wreg(W_ADDR, 32'h500); nb = 0;
        wreg(W_DATA, 32'h7);
        chk("R7 packed word single beat", nb, 1);
        rreg(W_ADDR, d); chk("R7 packed word step", d, 32'h504);
    endtask

    task automatic t_bank;
        logic [31:0] d;
        wreg(W_CTRL, 32'h10); wreg(W_ADDR, 32'h5A7); nb = 0;
        wreg(6'd6, 32'h1111_2222);
        chk("R8 one beat", nb, 1);
        chk("R8 banked address", la[0], 32'h5A8);
        chk("R8 word lanes", {28'b0, lbe[0]}, 32'hF);
        chk("R8 word size", {30'b0, lsz[0]}, 32'h2);
        rreg(W_ADDR, d); chk("R8 no step", d, 32'h5A7);
        rreg(6'd6, d); chk("R8 banked read", d, 32'h1111_2222);
    endtask

    task automatic t_gate;
        logic [31:0] d;
        dbg_en = 0;
        rreg(W_CTRL, d); chk("R9 status bit low", d, 32'h10);
        wreg(W_CTRL, 32'h12); wreg(W_ADDR, 32'h600); nb = 0;
        wreg(W_DATA, 32'h9);
        rreg(W_DATA, d); chk("R9 blocked read is zero", d, 32'h0);
        chk("R9 no beat while disabled", nb, 0);
        rreg(W_ADDR, d); chk("R9 address unchanged", d, 32'h600);
        dbg_en = 1;
        wreg(W_CTRL, 32'h20); wreg(W_ADDR, 32'h700); nb = 0; drop_at = 0;
        wreg(W_DATA, 32'h1122_3344);
        drop_at = -1; dbg_en = 1;
        chk("R9 pack cut after first beat", nb, 1);
        rreg(W_ADDR, d); chk("R9 step kept for ok beat", d, 32'h701);
    endtask

    task automatic t_rsvd;
        logic [31:0] d;
        wreg(W_CTRL, 32'h32); wreg(W_ADDR, 32'h800); nb = 0;
        wreg(W_DATA, 32'h1);
        chk("R10 mode 11 no beat", nb, 0);
        wreg(W_CTRL, 32'h13);
        wreg(W_DATA, 32'h1);
        chk("R10 size 011 no beat", nb, 0);
        rreg(W_ADDR, d); chk("R10 address unchanged", d, 32'h800);
    endtask

    task automatic t_hold;
        logic [31:0] d;
        int c0;
        lat = 3;
        mem[8'h40] = 32'h0BAD_CAFE;
        wreg(W_CTRL, 32'h12); wreg(W_ADDR, 32'h900); nb = 0;
        c0 = cyc;
        rreg(W_DATA, d);
        chk("R11 stalled read data", d, 32'h0BAD_CAFE);
        chk("R11 stall long enough", {31'b0, (cyc - c0) >= 5}, 32'h1);
        chk("R11 single beat", nb, 1);
        lat = 0;
        rreg(W_CTRL, d); chk("R11 not busy after", d & 32'h80, 32'h0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        t_reset;
        t_regs;
        t_single;
        t_wrap;
        t_err;
        t_pack_byte;
        t_pack_half;
        t_bank;
        t_gate;
        t_rsvd;
        t_hold;
        repeat (4) @(posedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule